// File: doc/BRIEF.md
# Capability Dereference Access Checker

This block sits in front of address translation and decides whether one memory access made through a capability may go ahead. A capability is a fat pointer: a validity tag, a sealed flag, a permission vector, and a base, length and offset. The access names its kind (load, store or instruction fetch) and its size in bytes. The block forms the effective virtual address as base plus offset. It checks the tag, the seal, the permission that matches the access kind and the byte span of the access against the capability's region. It then returns an allow flag and a cause code.

The decision logic is combinational. A single register stage holds the response, so a request presented in one cycle is answered in the next. When an access is refused, the address output is forced to zero so that nothing downstream can act on it. The offset may point anywhere, inside the region or outside it. Only a real dereference is judged against the bounds.

Top module: `cap_access_guard`

## Requirements
- R1: A request whose tag input is 0 is refused with cause code 1.
- R2: A tagged request through a sealed capability is refused with cause code 2.
- R3: Permission bits are: bit 2 for load (kind 0), bit 3 for store (kind 1), bit 1 for instruction fetch (kind 2). A tagged, unsealed request whose kind bit is clear is refused with cause code 3. Kind 3 is always refused with cause code 3.
- R4: A tagged, unsealed, permitted request is in bounds only when offset + size <= length, evaluated without wrap-around. Otherwise it is refused with cause code 4.
- R5: When several violations are present, the reported cause follows the order tag (1), seal (2), permission (3), bounds (4).
- R6: An allowed request gives allow = 1, cause 0, and an address equal to (base + offset) mod 2^64.
- R7: A refused request gives allow = 0 and an address of 0.
- R8: The response appears on the clock edge that follows the request. With no request, the outputs are valid = 0, allow = 0, cause = 0 and address = 0.
- R9: A size of 0 is checked as a one-byte access.
- R10: While reset is held, and right after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A check request is present |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability sealed flag |
| cap_perms | input | 31 | Permission vector |
| cap_base | input | 64 | Region base |
| cap_length | input | 64 | Region length in bytes |
| cap_offset | input | 64 | Pointer offset from base |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| acc_size | input | 4 | Access size in bytes |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access permitted |
| rsp_cause | output | 3 | 0 none, 1 tag, 2 seal, 3 permission, 4 bounds |
| rsp_addr | output | 64 | Effective address, 0 when refused |

## Verification
On every cycle, the assertions check the one-cycle response timing and the tag and seal causes. They also check that an allowed response has no cause, that a refused response carries no address, and that at most one violation wins the priority selection. Only the bench's sweeps can show the exact boundary of the bounds check. That sweep covers every offset and size around the end of the region, zero-length regions, spans that would wrap past 2^64, and the full cross of access kinds against permission subsets.

// File: rtl/cap_guard_pkg.sv
package cap_guard_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_TAG  = 3'd1,
    CAUSE_SEAL = 3'd2,
    CAUSE_PERM = 3'd3,
    CAUSE_LEN  = 3'd4
  } cause_e;

  // Start of the access, kept one bit wider than an address so no carry is lost.
  function automatic logic [64:0] span_start(input logic [63:0] base,
                                             input logic [63:0] offset);
    return {1'b0, base} + {1'b0, offset};
  endfunction

  // First byte past the access; a zero size counts as one byte.
  function automatic logic [65:0] span_end(input logic [64:0] start,
                                           input logic [3:0]  size);
    logic [3:0] eff;
    eff = (size == 4'd0) ? 4'd1 : size;
    return {1'b0, start} + {62'd0, eff};
  endfunction

  // First byte past the region.
  function automatic logic [65:0] region_top(input logic [63:0] base,
                                             input logic [63:0] length);
    return {2'b00, base} + {2'b00, length};
  endfunction

endpackage

// File: rtl/cg_perm_decode.sv
module cg_perm_decode
  import cap_guard_pkg::*;
#(
  parameter int PERM_W    = 31,
  parameter int LOAD_BIT  = 2,
  parameter int STORE_BIT = 3,
  parameter int FETCH_BIT = 1
) (
  input  logic [PERM_W-1:0] perms,
  input  acc_kind_e         kind,
  output logic              perm_ok
);

  logic [PERM_W-1:0] need_mask;

  always_comb begin
    need_mask = '0;
    unique case (kind)
      ACC_LOAD:  need_mask[LOAD_BIT]  = 1'b1;
      ACC_STORE: need_mask[STORE_BIT] = 1'b1;
      ACC_FETCH: need_mask[FETCH_BIT] = 1'b1;
      default:   need_mask            = '0;
    endcase
  end

  // An empty mask means the kind is reserved and never permitted.
  assign perm_ok = (need_mask != '0) && ((perms & need_mask) == need_mask);

  // R3
  always_comb begin
    perm_mask_chk: assert ($countones(need_mask) <= 1);
  end

endmodule

// File: rtl/cg_bounds_calc.sv
module cg_bounds_calc
  import cap_guard_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] length,
  input  logic [ADDR_W-1:0] offset,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              in_bounds
);

  logic [64:0] start_w;
  logic [65:0] end_w;
  logic [65:0] top_w;

  assign start_w   = span_start(base, offset);
  assign end_w     = span_end(start_w, size);
  assign top_w     = region_top(base, length);
  assign eff_addr  = start_w[ADDR_W-1:0];
  assign in_bounds = (end_w <= top_w);

  // R4: an in-bounds span never covers a zero-length region
  always_comb begin
    nonempty_region_chk: assert (!(in_bounds && length == '0));
  end

endmodule

// File: rtl/cg_cause_arb.sv
module cg_cause_arb
  import cap_guard_pkg::*;
(
  input  logic   tag_ok,
  input  logic   unsealed,
  input  logic   perm_ok,
  input  logic   in_bounds,
  output cause_e cause,
  output logic   allow
);

  logic [3:0] viol;
  logic [3:0] first_hit;

  assign viol = {~in_bounds, ~perm_ok, ~unsealed, ~tag_ok};

  // Lowest index has the highest priority.
  always_comb begin
    first_hit = '0;
    for (int i = 0; i < 4; i++) begin
      if (viol[i] && first_hit == '0) first_hit[i] = 1'b1;
    end
  end

  always_comb begin
    unique case (1'b1)
      first_hit[0]: cause = CAUSE_TAG;
      first_hit[1]: cause = CAUSE_SEAL;
      first_hit[2]: cause = CAUSE_PERM;
      first_hit[3]: cause = CAUSE_LEN;
      default:      cause = CAUSE_NONE;
    endcase
  end

  assign allow = (viol == '0);

  // R5
  always_comb begin
    single_winner_chk: assert ($onehot0(first_hit));
  end

endmodule

// File: rtl/cap_access_guard.sv
module cap_access_guard
  import cap_guard_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PERM_W    = 31,
  parameter int SIZE_W    = 4,
  parameter int LOAD_BIT  = 2,
  parameter int STORE_BIT = 3,
  parameter int FETCH_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              cap_tag,
  input  logic              cap_sealed,
  input  logic [PERM_W-1:0] cap_perms,
  input  logic [ADDR_W-1:0] cap_base,
  input  logic [ADDR_W-1:0] cap_length,
  input  logic [ADDR_W-1:0] cap_offset,
  input  logic [1:0]        acc_kind,
  input  logic [SIZE_W-1:0] acc_size,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic [2:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_addr
);

  logic              perm_ok;
  logic              in_bounds;
  logic [ADDR_W-1:0] eff_addr;
  cause_e            cause_d;
  logic              allow_d;

  cg_perm_decode #(
    .PERM_W(PERM_W), .LOAD_BIT(LOAD_BIT),
    .STORE_BIT(STORE_BIT), .FETCH_BIT(FETCH_BIT)
  ) u_perm (
    .perms  (cap_perms),
    .kind   (acc_kind_e'(acc_kind)),
    .perm_ok(perm_ok)
  );

  cg_bounds_calc #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bounds (
    .base     (cap_base),
    .length   (cap_length),
    .offset   (cap_offset),
    .size     (acc_size),
    .eff_addr (eff_addr),
    .in_bounds(in_bounds)
  );

  cg_cause_arb u_arb (
    .tag_ok   (cap_tag),
    .unsealed (~cap_sealed),
    .perm_ok  (perm_ok),
    .in_bounds(in_bounds),
    .cause    (cause_d),
    .allow    (allow_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_cause <= 3'd0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && allow_d;
      rsp_cause <= req_valid ? cause_d : CAUSE_NONE;
      rsp_addr  <= (req_valid && allow_d) ? eff_addr : '0;
    end
  end

  // R8
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  tag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cap_tag) |=> (rsp_cause == CAUSE_TAG && !rsp_allow));
  // R2
  seal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cap_tag && cap_sealed) |=> (rsp_cause == CAUSE_SEAL));
  // R6
  allow_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_allow |-> (rsp_cause == CAUSE_NONE && rsp_valid));
  // R7
  deny_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_allow |-> (rsp_addr == '0));

endmodule

// File: tb/sim_cap_access_guard.sv
module sim_cap_access_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        cap_tag = 1'b0;
  logic        cap_sealed = 1'b0;
  logic [30:0] cap_perms = '0;
  logic [63:0] cap_base = '0;
  logic [63:0] cap_length = '0;
  logic [63:0] cap_offset = '0;
  logic [1:0]  acc_kind = '0;
  logic [3:0]  acc_size = '0;
  logic        rsp_valid;
  logic        rsp_allow;
  logic [2:0]  rsp_cause;
  logic [63:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cap_access_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cap_tag(cap_tag),
    .cap_sealed(cap_sealed), .cap_perms(cap_perms), .cap_base(cap_base),
    .cap_length(cap_length), .cap_offset(cap_offset), .acc_kind(acc_kind),
    .acc_size(acc_size), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_cause(rsp_cause), .rsp_addr(rsp_addr)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected < 100000", cycles);
      finish_run();
    end
  end

  // Expected result from the requirements, bounds relative to the base.
  function automatic logic [2:0] want_cause(input logic t, input logic s,
      input logic [30:0] p, input logic [1:0] k, input logic [63:0] len,
      input logic [63:0] off, input logic [3:0] sz);
    logic [65:0] need;
    int pbit;
    if (!t) return 3'd1;                       // R1
    if (s)  return 3'd2;                       // R2
    pbit = (k == 2'd0) ? 2 : (k == 2'd1) ? 3 : (k == 2'd2) ? 1 : -1;
    if (pbit < 0 || !p[pbit]) return 3'd3;     // R3
    need = {2'b00, off} + ((sz == 4'd0) ? 66'd1 : {62'd0, sz});  // R9
    if (need > {2'b00, len}) return 3'd4;      // R4
    return 3'd0;
  endfunction

  task automatic expect_eq(input string req, input logic [63:0] got,
                           input logic [63:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, want);
    end
  endtask

  task automatic run_one(input logic t, input logic s, input logic [30:0] p,
      input logic [1:0] k, input logic [63:0] b, input logic [63:0] len,
      input logic [63:0] off, input logic [3:0] sz, input string req);
    logic [2:0] c;
    c = want_cause(t, s, p, k, len, off, sz);
    @(negedge clk);
    req_valid = 1'b1; cap_tag = t; cap_sealed = s; cap_perms = p;
    acc_kind = k; cap_base = b; cap_length = len; cap_offset = off; acc_size = sz;
    @(negedge clk);
    expect_eq({req, " valid"}, {63'd0, rsp_valid}, 64'd1);             // R8
    expect_eq({req, " cause"}, {61'd0, rsp_cause}, {61'd0, c});        // R5
    expect_eq({req, " allow"}, {63'd0, rsp_allow}, {63'd0, c == 3'd0}); // R6
    expect_eq({req, " addr"}, rsp_addr, (c == 3'd0) ? b + off : 64'd0); // R6 R7
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    expect_eq("R10 valid", {63'd0, rsp_valid}, 64'd0);
    expect_eq("R10 allow", {63'd0, rsp_allow}, 64'd0);
    expect_eq("R10 addr", rsp_addr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R10 after release", {60'd0, rsp_valid, rsp_cause}, 64'd0);

    // R4 R9: bounds sweep, load with full permissions
    for (int len = 0; len < 10; len++)
      for (int off = 0; off < 13; off++)
        for (int sz = 0; sz < 10; sz++)
          run_one(1'b1, 1'b0, 31'h7fffffff, 2'd0, 64'h1000, 64'(len),
                  64'(off), 4'(sz), "R4");

    // R1 R2 R3 R5: kind x permission subset x tag x seal, some out of bounds
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++)
          for (int pm = 0; pm < 8; pm++)
            for (int ob = 0; ob < 2; ob++)
              run_one(1'(t), 1'(s), {27'd0, 3'(pm), 1'b0}, 2'(k), 64'h2000,
                      64'd16, (ob != 0) ? 64'd15 : 64'd4, 4'd2, "R3 R5");

    // R4: spans near the top of the address space must not wrap and pass
    run_one(1'b1, 1'b0, 31'h7fffffff, 2'd1, 64'hffff_ffff_ffff_fff0, 64'd16,
            64'd12, 4'd4, "R4 top edge");
    run_one(1'b1, 1'b0, 31'h7fffffff, 2'd1, 64'hffff_ffff_ffff_fff0, 64'd16,
            64'd13, 4'd4, "R4 top over");
    run_one(1'b1, 1'b0, 31'h7fffffff, 2'd2, 64'h10, 64'd32,
            64'hffff_ffff_ffff_fff8, 4'd8, "R4 wrap offset");
    run_one(1'b1, 1'b0, 31'h7fffffff, 2'd0, 64'h0, 64'hffff_ffff_ffff_ffff,
            64'hffff_ffff_ffff_fffe, 4'd1, "R6 max region");

    // R8: idle cycle returns to quiet outputs
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    expect_eq("R8 idle", {rsp_addr[59:0], rsp_valid, rsp_allow, rsp_cause[1:0]},
              64'd0);
    expect_eq("R8 idle cause", {61'd0, rsp_cause}, 64'd0);
    finish_run();
  end

endmodule